// File: doc/BRIEF.md
# Channel Completion Interrupt Status Block

This block gathers completion events from four DMA channels into one pending-status word and raises a single interrupt line. Each channel pulses its completion input for one cycle when it finishes a job. The pulse latches a sticky pending bit for that channel. Software reads the pending word to learn which channels finished. It then writes a mask to a separate clear address to acknowledge them.

A control word holds one interrupt-enable bit per channel, next to two feature flags. The flags are stored and read back but do not affect this block. A channel-enable word, a 32-bit context-pointer word and a fixed capability word complete the register set. Reads are combinational from the offset on the bus. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low, except the capability word at offset 0x40, which reads 0x0005_0001.
- R2: A one-cycle pulse on `done_pulse[i]` sets pending bit i of the status word at offset 0x10 (bits 3:0) on the next clock edge. This happens whether or not interrupt enable bit i is set.
- R3: A write to offset 0x18 clears each pending bit whose position is 1 in `wdata[3:0]`. Pending bits under a 0 in the mask are kept. The offset 0x18 itself reads zero.
- R4: If a completion pulse and a clear for the same bit arrive in the same cycle, that bit is set after the edge.
- R5: `irq` is high exactly when at least one pending bit i is set together with interrupt enable bit i of the control word.
- R6: The control word at offset 0x00 stores bits 23 (gather flag), 22 (caching flag) and 3:0 (interrupt enables, bit i for channel i). All its other bits read zero.
- R7: The channel-enable word at offset 0x20 stores its low 8 bits. Its upper bits read zero.
- R8: The context-pointer word at offset 0x50 stores and returns all 32 bits that are written to it.
- R9: The capability word at offset 0x40 is read-only. Bit 0 means AES-128, bit 16 means SHA-1 and bit 18 means SHA-256. A write to it changes nothing.
- R10: A write to the status offset 0x10 changes no pending bit.
- R11: Any offset other than 0x00, 0x10, 0x18, 0x20, 0x40 and 0x50 reads zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, acts at the clock edge |
| addr | input | 8 | Byte offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| done_pulse | input | 4 | Per-channel completion pulses |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover these behaviours:
- a pulse always latches its pending bit;
- a clear without a coincident pulse empties the masked bits;
- pending bits outside the clear mask never drop;
- control, channel-enable and context words hold their value unless their own offset is written, and take the masked write data when it is.

Some behaviours can only be shown by the bench's scenarios, which read the registers back through the bus. These are:
- the read-back of every offset, including unmapped ones and the write-only clear alias;
- that writes to the capability word, the status word and unmapped offsets leave everything unchanged;
- the interrupt line's dependence on both pending bits and enables.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned OFF_CTRL   = 'h00;
    localparam int unsigned OFF_STAT   = 'h10;
    localparam int unsigned OFF_CLR    = 'h18;
    localparam int unsigned OFF_CHEN   = 'h20;
    localparam int unsigned OFF_CAP    = 'h40;
    localparam int unsigned OFF_CTX    = 'h50;

    localparam int unsigned CTRL_GATHER_BIT = 23;
    localparam int unsigned CTRL_CACHE_BIT  = 22;

    localparam int unsigned CAP_AES128_BIT  = 0;
    localparam int unsigned CAP_SHA1_BIT    = 16;
    localparam int unsigned CAP_SHA256_BIT  = 18;

    localparam logic [31:0] CAP_DEFAULT =
        (32'd1 << CAP_AES128_BIT) | (32'd1 << CAP_SHA1_BIT) | (32'd1 << CAP_SHA256_BIT);
endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] status_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set in the same cycle wins over a clear
        st_d.pend = (st_q.pend & ~clr_i) | done_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.pend;

    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i != '0) |=> ((status_o & $past(done_i)) == $past(done_i)));

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~done_i) != '0) |=> ((status_o & $past(clr_i & ~done_i)) == '0));

    a_r4_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~clr_i) != '0) |=>
            ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));
endmodule

// File: rtl/irq_agg_cfg.sv
module irq_agg_cfg
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CHEN_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_chen_i,
    input  logic              wr_ctx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [CHEN_W-1:0] chen_o,
    output logic [DATA_W-1:0] ctx_o
);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << CTRL_GATHER_BIT) | (DATA_W'(1) << CTRL_CACHE_BIT) |
        DATA_W'((64'd1 << NUM_CH) - 64'd1);

    typedef struct packed {
        logic              gather;
        logic              cache;
        logic [NUM_CH-1:0] ien;
        logic [CHEN_W-1:0] chen;
        logic [DATA_W-1:0] ctx;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl_i) begin
            cfg_d.gather = wdata_i[CTRL_GATHER_BIT];
            cfg_d.cache  = wdata_i[CTRL_CACHE_BIT];
            cfg_d.ien    = wdata_i[NUM_CH-1:0];
        end
        if (wr_chen_i) cfg_d.chen = wdata_i[CHEN_W-1:0];
        if (wr_ctx_i)  cfg_d.ctx  = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        ctrl_o                  = '0;
        ctrl_o[CTRL_GATHER_BIT] = cfg_q.gather;
        ctrl_o[CTRL_CACHE_BIT]  = cfg_q.cache;
        ctrl_o[NUM_CH-1:0]      = cfg_q.ien;
    end

    assign chen_o = cfg_q.chen;
    assign ctx_o  = cfg_q.ctx;

    a_r6_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_i |=> (ctrl_o == ($past(wdata_i) & CTRL_MASK)));

    a_r7_chen_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_chen_i |=> (chen_o == $past(wdata_i[CHEN_W-1:0])));

    a_r8_ctx_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctx_i |=> (ctx_o == $past(wdata_i)));

    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl_i || wr_chen_i || wr_ctx_i) |=>
            ($stable(ctrl_o) && $stable(chen_o) && $stable(ctx_o)));
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CHEN_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_CH-1:0] status_i,
    input  logic [DATA_W-1:0] ctrl_i,
    input  logic [CHEN_W-1:0] chen_i,
    input  logic [DATA_W-1:0] ctx_i,
    input  logic [DATA_W-1:0] cap_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFF_CTRL): rdata_o = ctrl_i;
            ADDR_W'(OFF_STAT): rdata_o[NUM_CH-1:0] = status_i;
            ADDR_W'(OFF_CHEN): rdata_o[CHEN_W-1:0] = chen_i;
            ADDR_W'(OFF_CAP):  rdata_o = cap_i;
            ADDR_W'(OFF_CTX):  rdata_o = ctx_i;
            default:           rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned CHEN_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [31:0] CAP_WORD = CAP_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_CH-1:0] done_pulse,
    output logic              irq
);
    logic              wr_ctrl, wr_chen, wr_ctx, wr_clr;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] status;
    logic [DATA_W-1:0] ctrl;
    logic [CHEN_W-1:0] chen;
    logic [DATA_W-1:0] ctx;

    assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign wr_chen  = wr_en && (addr == ADDR_W'(OFF_CHEN));
    assign wr_ctx   = wr_en && (addr == ADDR_W'(OFF_CTX));
    assign wr_clr   = wr_en && (addr == ADDR_W'(OFF_CLR));
    assign clr_mask = wr_clr ? wdata[NUM_CH-1:0] : '0;

    irq_agg_status #(.NUM_CH(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done_pulse),
        .clr_i    (clr_mask),
        .status_o (status)
    );

    irq_agg_cfg #(.NUM_CH(NUM_CH), .CHEN_W(CHEN_W), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wr_chen_i (wr_chen),
        .wr_ctx_i  (wr_ctx),
        .wdata_i   (wdata),
        .ctrl_o    (ctrl),
        .chen_o    (chen),
        .ctx_o     (ctx)
    );

    irq_agg_rdmux #(.NUM_CH(NUM_CH), .CHEN_W(CHEN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .addr_i   (addr),
        .status_i (status),
        .ctrl_i   (ctrl),
        .chen_i   (chen),
        .ctx_i    (ctx),
        .cap_i    (DATA_W'(CAP_WORD)),
        .rdata_o  (rdata)
    );

    assign irq = |(status & ctrl[NUM_CH-1:0]);
endmodule

// File: tb/sim_irq_status_agg.sv
module sim_irq_status_agg;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  done_pulse = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [3:0]  m_stat = '0;
    logic [31:0] m_ctrl = '0;
    logic [7:0]  m_chen = '0;
    logic [31:0] m_ctx  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done_pulse(done_pulse), .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h10: return {28'd0, m_stat};
            8'h20: return {24'd0, m_chen};
            8'h40: return 32'h0005_0001;
            8'h50: return m_ctx;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_stat & m_ctrl[3:0]);
    endfunction

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] p);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; done_pulse = p;
        @(posedge clk);
        if (w) begin
            case (a)
                8'h00: m_ctrl = d & 32'h00C0_000F;
                8'h20: m_chen = d[7:0];
                8'h50: m_ctx  = d;
                8'h18: m_stat = m_stat & ~d[3:0];
                default: ;
            endcase
        end
        m_stat = m_stat | p;
    endtask

    task automatic chk(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        wr_en = 1'b0; done_pulse = '0; addr = a;
        #1;
        e = exp_read(a);
        n_chk++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s read @%02h: got %08h expected %08h", tag, a, rdata, e);
        end
        n_chk++;
        if (irq !== exp_irq()) begin
            n_bad++;
            $display("FAIL R5 irq (%s): got %0b expected %0b", tag, irq, exp_irq());
        end
    endtask

    task automatic chk_all(input string tag);
        chk(8'h00, tag); chk(8'h10, tag); chk(8'h20, tag);
        chk(8'h40, tag); chk(8'h50, tag); chk(8'h18, tag);
    endtask

    function automatic logic [7:0] pick_addr();
        case ($urandom_range(0, 6))
            0: return 8'h00;
            1: return 8'h10;
            2: return 8'h18;
            3: return 8'h20;
            4: return 8'h40;
            5: return 8'h50;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin : watchdog
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > WDOG_LIMIT && !finished) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WDOG_LIMIT);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk_all("R1");

        // R2: pulse with enables off still latches
        step(1'b1, 8'h00, 32'h0, 4'b0000);
        step(1'b0, 8'h00, 32'h0, 4'b0101);
        chk(8'h10, "R2");

        // R5: enable one pending channel raises irq
        step(1'b1, 8'h00, 32'h0000_0004, 4'b0000);
        chk(8'h00, "R5");

        // R3: partial clear
        step(1'b1, 8'h18, 32'h0000_0001, 4'b0000);
        chk(8'h10, "R3");
        chk(8'h18, "R3");

        // R4: simultaneous set and clear of bit 2
        step(1'b1, 8'h18, 32'h0000_0004, 4'b0100);
        chk(8'h10, "R4");

        // R10: write to status offset ignored
        step(1'b1, 8'h10, 32'h0000_0000, 4'b0000);
        chk(8'h10, "R10");

        // R6: control bit mask
        step(1'b1, 8'h00, 32'hFFFF_FFFF, 4'b0000);
        chk(8'h00, "R6");

        // R7: channel-enable width
        step(1'b1, 8'h20, 32'hDEAD_BEEF, 4'b0000);
        chk(8'h20, "R7");

        // R8: full context word
        step(1'b1, 8'h50, 32'hA5C3_0F96, 4'b0000);
        chk(8'h50, "R8");

        // R9: capability read-only
        step(1'b1, 8'h40, 32'h0000_0000, 4'b0000);
        chk_all("R9");

        // R11: unmapped writes ignored, reads zero
        step(1'b1, 8'h04, 32'h0000_0000, 4'b0000);
        step(1'b1, 8'h30, 32'h0000_0000, 4'b0000);
        step(1'b1, 8'hFF, 32'h1234_5678, 4'b0000);
        step(1'b1, 8'h51, 32'h0000_0000, 4'b0000);
        chk_all("R11");
        chk(8'h04, "R11");
        chk(8'hFC, "R11");

        // random mix covering R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 1) == 1, pick_addr(), $urandom(),
                 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)));
            if (i % 4 == 3) chk(pick_addr(), "R2-mix");
        end
        chk_all("R3");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule